// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel that sits next to a shared free-running counter. The counter is not part of the block: its value arrives on `cnt_value` together with a one-cycle advance strobe `cnt_tick`. Compare events are only evaluated in cycles where that strobe is high. The channel holds an 8-bit mode register and a capture/compare register as wide as the counter.

The mode bits select what the channel does:
- copy the counter on selected edges of an input pin;
- raise a flag when the counter equals the compare value;
- toggle an output pin on a compare hit;
- produce half-width or full-width pulse-width modulation;
- produce a square wave whose period is set by a step value. This mode is selected when PWM and toggle are both enabled.

A flag records captures and matches. The flag drives an interrupt request that software can mask.

Internally, a mode decoder maps the mode bits onto one operating state: OP_OFF, OP_MATCH, OP_TOGGLE, OP_PWM8, OP_PWM16 or OP_FREQ. A two-state pin machine then runs from that operating state. Its states are PIN_LO and PIN_HI. It has two transitions:
- the set-high transition (PIN_LO to PIN_HI);
- the set-low transition (PIN_HI to PIN_LO).

A toggle fires both transitions' conditions, so the pin moves whichever way is open.

Top module: `cc_channel`

## Requirements
- R1: Reset clears the mode register, the capture/compare register, the flag and the pin, and leaves the interrupt request low. The mode bits are:
  - bit 0: interrupt enable
  - bit 1: PWM enable
  - bit 2: toggle enable
  - bit 3: match enable
  - bit 4: falling-edge capture
  - bit 5: rising-edge capture
  - bit 6: compare enable
  - bit 7: wide PWM select
- R2: With bits 6 and 3 set, a strobed cycle in which the counter equals the capture/compare register sets the flag at the next clock. A mismatch leaves the flag clear.
- R3: With bits 6 and 2 set and bit 1 clear (state OP_TOGGLE), each strobed full-width match inverts the pin at the next clock.
- R4: With bits 6, 2 and 1 set (OP_FREQ), behaviour on a strobed cycle is as follows:
  - If the counter low half equals the register low half, the pin inverts and the register low half becomes its low half plus its high half.
  - A counter low half of zero has no effect on the pin.
- R5: With bits 6 and 1 set, bit 2 clear and bit 7 clear (OP_PWM8), behaviour on a strobed cycle is as follows:
  - A counter low half of zero drives the pin high and copies the register high half into its low half.
  - A low-half match drives the pin low.
  - Going high wins when both happen in the same cycle.
- R6: With bits 7, 6 and 1 set and bit 2 clear (OP_PWM16), behaviour on a strobed cycle is as follows:
  - A counter of zero drives the pin high.
  - A full-width match drives the pin low.
  - A low half of zero with a nonzero high half has no effect.
- R7: Bit 5 enables capture on rising input edges and bit 4 on falling ones, independently. A qualified edge copies the counter into the register and sets the flag. An edge whose enable is clear changes neither.
- R8: The interrupt request is high only while the flag is set and bit 0 is 1.
- R9: With bit 6 clear, matches set no flag and never move the pin, and the pin is held low (OP_OFF).
- R10: The input passes through two synchronizer stages and an edge register. A capture therefore lands on the third rising clock edge after the input changes, and takes the counter value present at that edge.
- R11: The flag stays set until a clear strobe. A set event in the same cycle as a clear leaves the flag set.
- R12: A write to the capture/compare register is visible on `cc_value` right after the next clock. It takes priority over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_value | input | CNT_W | Shared counter value |
| cnt_tick | input | 1 | Counter advance strobe; qualifies compare events |
| cap_in | input | 1 | Asynchronous capture input pin |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| cmp_wr | input | 1 | Capture/compare register write strobe |
| cmp_wdata | input | CNT_W | Capture/compare register write data |
| flag_clr | input | 1 | Flag clear strobe |
| cc_value | output | CNT_W | Capture/compare register contents |
| pin_out | output | 1 | Channel output pin |
| flag | output | 1 | Capture/compare flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions watch several properties on every cycle:
- the flag sets on a qualified full-width match;
- a toggle-mode hit flips the pin;
- the pin stays low while compare is disabled;
- the flag persists until cleared;
- the interrupt never rises without the flag;
- register writes land one clock later.

Other behaviours only the bench scenarios can show. These are the synchronizer latency and the value a capture records, the reload and step arithmetic of the half-width PWM and square-wave modes, and the ignored wrap events in full-width PWM and square-wave modes.

// File: rtl/cc_pkg.sv
package cc_pkg;

    // Mode register layout, most significant field first.
    typedef struct packed {
        logic wide;   // bit 7: full-width PWM
        logic ecom;   // bit 6: compare logic enable
        logic capp;   // bit 5: rising-edge capture
        logic capn;   // bit 4: falling-edge capture
        logic mat;    // bit 3: match sets flag
        logic tog;    // bit 2: toggle on match
        logic pwm;    // bit 1: PWM enable
        logic ien;    // bit 0: interrupt enable
    } cc_mode_t;

    // Operating state decoded from the mode register.
    typedef enum logic [2:0] {
        OP_OFF    = 3'd0,
        OP_MATCH  = 3'd1,
        OP_TOGGLE = 3'd2,
        OP_PWM8   = 3'd3,
        OP_PWM16  = 3'd4,
        OP_FREQ   = 3'd5
    } cc_op_e;

    // Output pin state.
    typedef enum logic {
        PIN_LO = 1'b0,
        PIN_HI = 1'b1
    } cc_pin_e;

endpackage

// File: rtl/cc_edge_sync.sv
module cc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    // Synchronizer chain, then one register holding the previous synced level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[LAST-1:0], pin_in};
            prev_q <= sync_q[LAST];
        end
    end

    assign rise = sync_q[LAST] & ~prev_q;
    assign fall = ~sync_q[LAST] & prev_q;

endmodule

// File: rtl/cc_mode_dec.sv
module cc_mode_dec
    import cc_pkg::*;
(
    input  logic   ecom,
    input  logic   pwm,
    input  logic   tog,
    input  logic   wide,
    output cc_op_e op
);
    always_comb begin
        if (!ecom) begin
            op = OP_OFF;
        end else if (pwm && tog) begin
            op = OP_FREQ;
        end else if (pwm) begin
            op = wide ? OP_PWM16 : OP_PWM8;
        end else if (tog) begin
            op = OP_TOGGLE;
        end else begin
            op = OP_MATCH;
        end
    end

endmodule

// File: rtl/cc_pin_fsm.sv
module cc_pin_fsm
    import cc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cc_op_e           op,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic [CNT_W-1:0] cc_value,
    output logic             pin_out,
    output logic             reload_lo,
    output logic             adv_lo
);
    localparam int HALF_W = CNT_W / 2;

    cc_pin_e state_q, state_d;
    logic    hit_full, hit_low, wrap_full, wrap_low;
    logic    set_hi, set_lo;

    assign hit_full  = (cnt_value == cc_value);
    assign hit_low   = (cnt_value[HALF_W-1:0] == cc_value[HALF_W-1:0]);
    assign wrap_full = (cnt_value == '0);
    assign wrap_low  = (cnt_value[HALF_W-1:0] == '0);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition conditions per operating state.
    always_comb begin
        set_hi    = 1'b0;
        set_lo    = 1'b0;
        reload_lo = 1'b0;
        adv_lo    = 1'b0;
        unique case (op)
            OP_OFF, OP_MATCH: begin
                set_lo = 1'b1;
            end
            OP_TOGGLE: begin
                set_hi = tick & hit_full;
                set_lo = tick & hit_full;
            end
            OP_PWM8: begin
                set_hi    = tick & wrap_low;
                set_lo    = tick & hit_low & ~wrap_low;
                reload_lo = tick & wrap_low;
            end
            OP_PWM16: begin
                set_hi = tick & wrap_full;
                set_lo = tick & hit_full & ~wrap_full;
            end
            OP_FREQ: begin
                set_hi = tick & hit_low;
                set_lo = tick & hit_low;
                adv_lo = tick & hit_low;
            end
            default: begin
                set_lo = 1'b1;
            end
        endcase
    end

    // Next state and pin output.
    always_comb begin
        unique case (state_q)
            PIN_LO:  state_d = set_hi ? PIN_HI : PIN_LO;
            PIN_HI:  state_d = set_lo ? PIN_LO : PIN_HI;
            default: state_d = PIN_LO;
        endcase
        pin_out = (state_q == PIN_HI);
    end

endmodule

// File: rtl/cc_channel.sv
module cc_channel
    import cc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             cnt_tick,
    input  logic             cap_in,
    input  logic             mode_wr,
    input  logic [7:0]       mode_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cc_value,
    output logic             pin_out,
    output logic             flag,
    output logic             irq
);
    localparam int HALF_W = CNT_W / 2;

    cc_mode_t         mode_r;
    logic [CNT_W-1:0] cc_r;
    logic             flag_r;
    cc_op_e           op;
    logic             rise, fall;
    logic             cap_evt, match_evt;
    logic             reload_lo, adv_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r <= '0;
        end else if (mode_wr) begin
            mode_r <= cc_mode_t'(mode_wdata);
        end
    end

    cc_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (cap_in),
        .rise   (rise),
        .fall   (fall)
    );

    cc_mode_dec u_dec (
        .ecom (mode_r.ecom),
        .pwm  (mode_r.pwm),
        .tog  (mode_r.tog),
        .wide (mode_r.wide),
        .op   (op)
    );

    cc_pin_fsm #(
        .CNT_W (CNT_W)
    ) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .tick      (cnt_tick),
        .cnt_value (cnt_value),
        .cc_value  (cc_r),
        .pin_out   (pin_out),
        .reload_lo (reload_lo),
        .adv_lo    (adv_lo)
    );

    assign cap_evt   = (mode_r.capp & rise) | (mode_r.capn & fall);
    assign match_evt = mode_r.ecom & mode_r.mat & cnt_tick & (cnt_value == cc_r);

    // Capture/compare register: write, then capture, then PWM reload, then step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_r <= '0;
        end else if (cmp_wr) begin
            cc_r <= cmp_wdata;
        end else if (cap_evt) begin
            cc_r <= cnt_value;
        end else if (reload_lo) begin
            cc_r[HALF_W-1:0] <= cc_r[CNT_W-1:HALF_W];
        end else if (adv_lo) begin
            cc_r[HALF_W-1:0] <= cc_r[HALF_W-1:0] + cc_r[CNT_W-1:HALF_W];
        end
    end

    // Flag: a set event outranks a clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_r <= 1'b0;
        end else if (cap_evt || match_evt) begin
            flag_r <= 1'b1;
        end else if (flag_clr) begin
            flag_r <= 1'b0;
        end
    end

    assign cc_value = cc_r;
    assign flag     = flag_r;
    assign irq      = flag_r & mode_r.ien;

endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_value,
    input logic             cnt_tick,
    input logic             cmp_wr,
    input logic [CNT_W-1:0] cmp_wdata,
    input logic             flag_clr,
    input logic [7:0]       mode_q,
    input logic [CNT_W-1:0] cc_value,
    input logic             pin_out,
    input logic             flag,
    input logic             irq
);
    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[6] && mode_q[3] && cnt_tick && cnt_value == cc_value) |=> flag); // R2

    AST_TOGGLE_FLIPS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[6] && mode_q[2] && !mode_q[1] && cnt_tick && cnt_value == cc_value)
        |=> pin_out != $past(pin_out)); // R3

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R8

    AST_OFF_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[6] |=> !pin_out); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag); // R11

    AST_CMP_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> cc_value == $past(cmp_wdata)); // R12

endmodule

bind cc_channel cc_channel_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_value (cnt_value),
    .cnt_tick  (cnt_tick),
    .cmp_wr    (cmp_wr),
    .cmp_wdata (cmp_wdata),
    .flag_clr  (flag_clr),
    .mode_q    (mode_r),
    .cc_value  (cc_value),
    .pin_out   (pin_out),
    .flag      (flag),
    .irq       (irq)
);

// File: tb/cc_channel_bench.sv
`timescale 1ns/1ps
module cc_channel_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_value = '0;
    logic         cnt_tick = 1'b0;
    logic         cap_in = 1'b0;
    logic         mode_wr = 1'b0;
    logic [7:0]   mode_wdata = '0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         flag_clr = 1'b0;
    logic [W-1:0] cc_value;
    logic         pin_out, flag, irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cc_channel #(.CNT_W(W)) u_cc_channel (
        .clk(clk), .rst_n(rst_n), .cnt_value(cnt_value), .cnt_tick(cnt_tick),
        .cap_in(cap_in), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .flag_clr(flag_clr),
        .cc_value(cc_value), .pin_out(pin_out), .flag(flag), .irq(irq)
    );

    // {mode, cmp, cnt, exp flag, exp irq, exp pin, requirement}
    localparam logic [46:0] VEC [0:7] = '{
        {8'h48, 16'h1234, 16'h1234, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 match
        {8'h49, 16'h1234, 16'h1234, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 irq enabled
        {8'h49, 16'h1234, 16'h1235, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 mismatch
        {8'h08, 16'h1234, 16'h1234, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 no compare enable
        {8'h44, 16'h1234, 16'h1234, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 toggle
        {8'h04, 16'h1234, 16'h1234, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 toggle gated
        {8'h4C, 16'h1234, 16'h1234, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 toggle plus flag
        {8'h44, 16'h1234, 16'h1235, 1'b0, 1'b0, 1'b0, 4'd3}   // R3 no hit
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_mode(input logic [7:0] m);
        mode_wr = 1'b1; mode_wdata = m;
        step();
        mode_wr = 1'b0;
    endtask

    task automatic wr_cmp(input logic [W-1:0] v);
        cmp_wr = 1'b1; cmp_wdata = v;
        step();
        cmp_wr = 1'b0;
    endtask

    task automatic clear_all(input logic [W-1:0] v);
        mode_wr = 1'b1; mode_wdata = 8'h00; flag_clr = 1'b1;
        cmp_wr = 1'b1; cmp_wdata = v;
        step();
        mode_wr = 1'b0; flag_clr = 1'b0; cmp_wr = 1'b0;
    endtask

    task automatic tick_at(input logic [W-1:0] v);
        cnt_value = v; cnt_tick = 1'b1;
        step();
        cnt_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk("R1", "flag", flag, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "pin", pin_out, 0);
        chk("R1", "cc", cc_value, 0);
        tick_at(16'h0000);
        chk("R1", "flag after zero match with reset mode", flag, 0);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            clear_all(VEC[i][38:23]);
            wr_mode(VEC[i][46:39]);
            tick_at(VEC[i][22:7]);
            chk($sformatf("R%0d", VEC[i][3:0]), $sformatf("vec%0d flag", i), flag, VEC[i][6]);
            chk($sformatf("R%0d", VEC[i][3:0]), $sformatf("vec%0d irq", i), irq, VEC[i][5]);
            chk($sformatf("R%0d", VEC[i][3:0]), $sformatf("vec%0d pin", i), pin_out, VEC[i][4]);
        end

        // R7 / R10: rising capture, latency three edges
        clear_all(16'h0000);
        wr_mode(8'h20);
        cnt_value = 16'hABCD;
        cap_in = 1'b1;
        step(); step();
        chk("R10", "cc before third edge", cc_value, 16'h0000);
        chk("R10", "flag before third edge", flag, 0);
        step();
        chk("R10", "cc on third edge", cc_value, 16'hABCD);
        chk("R7", "flag after rising capture", flag, 1);
        chk("R8", "irq masked", irq, 0);
        // R7: falling edge with its enable clear
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        cnt_value = 16'h1111;
        cap_in = 1'b0;
        repeat (4) step();
        chk("R7", "cc unchanged on disabled fall", cc_value, 16'hABCD);
        chk("R7", "flag clear on disabled fall", flag, 0);
        // R7: both edges enabled
        wr_mode(8'h30);
        cnt_value = 16'h2222;
        cap_in = 1'b1;
        repeat (3) step();
        chk("R7", "cc on rise with both", cc_value, 16'h2222);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        cnt_value = 16'h3333;
        cap_in = 1'b0;
        repeat (3) step();
        chk("R7", "cc on fall with both", cc_value, 16'h3333);
        chk("R7", "flag on fall with both", flag, 1);

        // R5: half-width PWM
        clear_all(16'h80C0);
        wr_mode(8'h42);
        tick_at(16'h0100);
        chk("R5", "pin high on low wrap", pin_out, 1);
        chk("R5", "low half reloaded", cc_value, 16'h8080);
        tick_at(16'h0180);
        chk("R5", "pin low on low-half match", pin_out, 0);

        // R6: full-width PWM
        clear_all(16'h0300);
        wr_mode(8'hC2);
        tick_at(16'h0000);
        chk("R6", "pin high on overflow", pin_out, 1);
        tick_at(16'h0100);
        chk("R6", "low-half wrap ignored", pin_out, 1);
        tick_at(16'h0300);
        chk("R6", "pin low on full match", pin_out, 0);
        tick_at(16'h0000);
        chk("R6", "pin high again", pin_out, 1);

        // R4: square-wave mode
        clear_all(16'h1020);
        wr_mode(8'h46);
        tick_at(16'h0020);
        chk("R4", "pin toggled high", pin_out, 1);
        chk("R4", "low half stepped", cc_value, 16'h1030);
        tick_at(16'h0100);
        chk("R4", "wrap ignored", pin_out, 1);
        tick_at(16'h0030);
        chk("R4", "pin toggled low", pin_out, 0);
        chk("R4", "low half stepped again", cc_value, 16'h1040);

        // R11: set beats clear, then clear alone
        clear_all(16'h0055);
        wr_mode(8'h48);
        flag_clr = 1'b1;
        tick_at(16'h0055);
        flag_clr = 1'b0;
        chk("R11", "set wins over clear", flag, 1);
        step();
        chk("R11", "flag holds", flag, 1);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        chk("R11", "flag cleared", flag, 0);

        // R12: register write visible next clock
        wr_cmp(16'hBEEF);
        chk("R12", "cc after write", cc_value, 16'hBEEF);

        finish_run();
    end

endmodule